// File: doc/BRIEF.md
# Linked Descriptor Chain Sequencer

This block steers one DMA channel through a chain of descriptors kept in memory. Each descriptor starts with a 64-bit pointer to the next one. The pointer's low 32 bits sit at the descriptor address and its high 32 bits sit four bytes above that. A start command names the head descriptor. For each descriptor the sequencer reads the two pointer words through a simple memory read port. It then hands the descriptor address to an external data mover and waits for that transfer's completion report. When the transfer is done it follows the pointer. A pointer of all zeroes ends the chain.

Software can grow or rewire a live chain. It first sets the suspend control bit, which parks the channel at the next descriptor boundary. It then edits pointers in memory and writes the control register again with suspend cleared and resume set. A resume always re-reads both pointer words of the current descriptor before moving on. This means an edit made after the first read is still honoured. The same re-read applies when the channel has already gone idle at the end of the chain, so new descriptors can be appended there too. The current descriptor address is visible as a low/high word pair so software can locate the splice point.

A fatal transfer error stops the channel and raises abort. While abort is raised, resume requests are dropped. A non-fatal error only raises a sticky error flag and the walk goes on.

Top module: `desc_chain_seq`

## Requirements
- R1: A start command (`ctl_wr` with `ctl_start`) is accepted only while `busy` is low. An accepted start begins a memory read at `start_addr` in the cycle after the write. A start written while busy has no effect on the descriptors executed.
- R2: For each descriptor at address A, the sequencer reads the pointer's low word at A and its high word at A+4. It holds `mem_req` and `mem_addr` until `mem_ack`. It executes descriptors in linked order, using all 64 pointer bits.
- R3: When a completed descriptor's pointer is all zero, the channel returns to idle and `sts_eoc` rises.
- R4: A transfer that completes with `xfer_err` (and not `xfer_fatal`) sets `sts_err` and the chain continues.
- R5: A transfer that completes with `xfer_fatal` sets `sts_abort`, returns the channel to idle, and no further descriptor is executed.
- R6: A resume written while `sts_abort` is set is discarded. Nothing is fetched or executed, and the channel stays idle.
- R7: While the suspend bit is set, the channel stops after the running transfer completes and raises `parked`. It starts no transfer and no memory read until the control register is written again.
- R8: An accepted resume re-reads both pointer words of the current descriptor and follows the value found in memory. This holds when the resume arrives while parked and also when it arrives during a running transfer.
- R9: A resume written while idle with `sts_eoc` set clears `sts_eoc` within three cycles, re-reads the last descriptor, and executes any descriptors appended to it.
- R10: Writing `sts_wr` with a one in `sts_clr` bit 0, 1 or 2 clears `sts_eoc`, `sts_abort` or `sts_err` respectively.
- R11: `{cur_hi, cur_lo}` equals the address of the descriptor being executed or last executed, and it equals `xfer_desc` whenever `xfer_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_start | input | 1 | Control write data: start command |
| ctl_susp | input | 1 | Control write data: suspend bit value |
| ctl_res | input | 1 | Control write data: resume request (self-clearing) |
| start_addr | input | 64 | Head descriptor address used by a start |
| sts_wr | input | 1 | Status write strobe |
| sts_clr | input | 3 | Write-one-to-clear mask: bit0 end of chain, bit1 abort, bit2 error |
| sts_eoc | output | 1 | End-of-chain status |
| sts_abort | output | 1 | Abort status |
| sts_err | output | 1 | Non-fatal error status |
| busy | output | 1 | Channel not idle |
| parked | output | 1 | Channel stopped at a boundary by suspend |
| cur_lo | output | 32 | Current descriptor address, low word |
| cur_hi | output | 32 | Current descriptor address, high word |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 64 | Memory read byte address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| xfer_req | output | 1 | Request to data mover to run the current descriptor |
| xfer_desc | output | 64 | Descriptor address handed to the data mover |
| xfer_done | input | 1 | Data mover completion pulse |
| xfer_err | input | 1 | With done: non-fatal error |
| xfer_fatal | input | 1 | With done: fatal error |

## Verification
The walk is tried with randomly sized chains. Some chains have pointers with non-zero high words and some have random non-fatal errors, so the test can tell a full 64-bit pointer follow from a truncated one, and a continuing walk from one that stops on error. Directed chains then cover four cases:
- a start written while busy;
- a fatal error in the middle of a chain, followed by a resume that must be discarded;
- an append after end of chain;
- a splice while parked, and an append written during the last running transfer.

Each directed case separates the re-read behaviour from a walk that relies on the stale pointer.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    localparam int PTR_W  = 64;
    localparam int WORD_W = 32;
    localparam int STS_W  = 3;
    localparam logic [PTR_W-1:0] HI_OFS = PTR_W'(WORD_W / 8);

    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        S_IDLE, S_FLO, S_FHI, S_RUN, S_PARK, S_RLO, S_RHI
    } seq_st_e;

    typedef struct packed {
        logic set_eoc;
        logic set_abort;
        logic set_err;
        logic take_res;
        logic took_start;
    } seq_evt_t;

    typedef struct packed {
        logic err;
        logic abort;
        logic eoc;
    } chan_sts_t;

    function automatic logic ptr_is_null(ptr_t p);
        return p == '0;
    endfunction
endpackage

// File: rtl/dcs_regs.sv
module dcs_regs
    import dcs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctl_wr,
    input  logic                 ctl_susp,
    input  logic                 ctl_res,
    input  logic                 sts_wr,
    input  logic [STS_W-1:0]     sts_clr,
    input  logic                 busy,
    input  seq_evt_t             evt,
    output logic                 susp_q,
    output logic                 res_pend,
    output chan_sts_t            sts
);
    always_ff @(posedge clk) begin
        if (rst) begin
            susp_q   <= 1'b0;
            res_pend <= 1'b0;
            sts      <= '0;
        end else begin
            if (ctl_wr) susp_q <= ctl_susp;

            // pending resume: dropped when taken, when abort appears, or when idle cannot use it
            if (evt.take_res || evt.set_abort || (!busy && res_pend))
                res_pend <= 1'b0;
            else if (ctl_wr && ctl_res && !sts.abort)
                res_pend <= 1'b1;

            if (evt.set_eoc)
                sts.eoc <= 1'b1;
            else if (evt.take_res || evt.took_start || (sts_wr && sts_clr[0]))
                sts.eoc <= 1'b0;

            if (evt.set_abort)
                sts.abort <= 1'b1;
            else if (sts_wr && sts_clr[1])
                sts.abort <= 1'b0;

            if (evt.set_err)
                sts.err <= 1'b1;
            else if (sts_wr && sts_clr[2])
                sts.err <= 1'b0;
        end
    end

    assert_abort_blocks_resume_R6: assert property (@(posedge clk) disable iff (rst)
        sts.abort |=> !res_pend);

    assert_resume_clears_eoc_R9: assert property (@(posedge clk) disable iff (rst)
        (evt.take_res && !evt.set_eoc) |=> !sts.eoc);

    assert_w1c_abort_R10: assert property (@(posedge clk) disable iff (rst)
        (sts_wr && sts_clr[1] && !evt.set_abort) |=> !sts.abort);
endmodule

// File: rtl/dcs_seq.sv
module dcs_seq
    import dcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_cmd,
    input  ptr_t       start_addr,
    input  logic       susp,
    input  logic       res_pend,
    input  logic       abort_q,
    input  logic       eoc_q,
    input  logic       mem_ack,
    input  word_t      mem_rdata,
    input  logic       xfer_done,
    input  logic       xfer_err,
    input  logic       xfer_fatal,
    output logic       mem_req,
    output ptr_t       mem_addr,
    output logic       xfer_req,
    output ptr_t       cur,
    output logic       busy,
    output logic       parked,
    output seq_evt_t   evt
);
    seq_st_e st, st_n;
    ptr_t    cur_n, nxt, nxt_n;
    ptr_t    reread;

    assign reread   = {mem_rdata, nxt[WORD_W-1:0]};
    assign mem_req  = (st == S_FLO) || (st == S_FHI) || (st == S_RLO) || (st == S_RHI);
    assign mem_addr = ((st == S_FHI) || (st == S_RHI)) ? cur + HI_OFS : cur;
    assign xfer_req = (st == S_RUN);
    assign busy     = (st != S_IDLE);
    assign parked   = (st == S_PARK);

    always_comb begin
        st_n  = st;
        cur_n = cur;
        nxt_n = nxt;
        evt   = '0;
        unique case (st)
            S_IDLE: begin
                if (start_cmd) begin
                    evt.took_start = 1'b1;
                    cur_n          = start_addr;
                    st_n           = S_FLO;
                end else if (res_pend && eoc_q && !abort_q) begin
                    evt.take_res = 1'b1;
                    st_n         = S_RLO;
                end
            end
            S_FLO, S_RLO: begin
                if (mem_ack) begin
                    nxt_n[WORD_W-1:0] = mem_rdata;
                    st_n = (st == S_FLO) ? S_FHI : S_RHI;
                end
            end
            S_FHI: begin
                if (mem_ack) begin
                    nxt_n[PTR_W-1:WORD_W] = mem_rdata;
                    st_n = S_RUN;
                end
            end
            S_RHI: begin
                if (mem_ack) begin
                    nxt_n = reread;
                    if (ptr_is_null(reread)) begin
                        evt.set_eoc = 1'b1;
                        st_n        = S_IDLE;
                    end else begin
                        cur_n = reread;
                        st_n  = S_FLO;
                    end
                end
            end
            S_RUN: begin
                if (xfer_done) begin
                    if (xfer_fatal) begin
                        evt.set_abort = 1'b1;
                        st_n          = S_IDLE;
                    end else begin
                        evt.set_err = xfer_err;
                        if (susp) begin
                            st_n = S_PARK;
                        end else if (res_pend) begin
                            evt.take_res = 1'b1;
                            st_n         = S_RLO;
                        end else if (ptr_is_null(nxt)) begin
                            evt.set_eoc = 1'b1;
                            st_n        = S_IDLE;
                        end else begin
                            cur_n = nxt;
                            st_n  = S_FLO;
                        end
                    end
                end
            end
            S_PARK: begin
                if (!susp) begin
                    if (res_pend) begin
                        evt.take_res = 1'b1;
                        st_n         = S_RLO;
                    end else if (ptr_is_null(nxt)) begin
                        evt.set_eoc = 1'b1;
                        st_n        = S_IDLE;
                    end else begin
                        cur_n = nxt;
                        st_n  = S_FLO;
                    end
                end
            end
            default: st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_IDLE;
            cur <= '0;
            nxt <= '0;
        end else begin
            st  <= st_n;
            cur <= cur_n;
            nxt <= nxt_n;
        end
    end

    assert_idle_needs_command_R1: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && !start_cmd && !(res_pend && eoc_q && !abort_q)) |=> st == S_IDLE);

    assert_read_held_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_fatal_stops_R5: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && xfer_done && xfer_fatal) |=> (!xfer_req && !mem_req));

    assert_park_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (st == S_PARK && susp) |=> st == S_PARK);

    assert_reread_no_run_R8: assert property (@(posedge clk) disable iff (rst)
        (st == S_RHI && mem_ack) |=> (st == S_FLO || st == S_IDLE));
endmodule

// File: rtl/desc_chain_seq.sv
module desc_chain_seq
    import dcs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctl_wr,
    input  logic                 ctl_start,
    input  logic                 ctl_susp,
    input  logic                 ctl_res,
    input  logic [PTR_W-1:0]     start_addr,
    input  logic                 sts_wr,
    input  logic [STS_W-1:0]     sts_clr,
    output logic                 sts_eoc,
    output logic                 sts_abort,
    output logic                 sts_err,
    output logic                 busy,
    output logic                 parked,
    output logic [WORD_W-1:0]    cur_lo,
    output logic [WORD_W-1:0]    cur_hi,
    output logic                 mem_req,
    output logic [PTR_W-1:0]     mem_addr,
    input  logic                 mem_ack,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 xfer_req,
    output logic [PTR_W-1:0]     xfer_desc,
    input  logic                 xfer_done,
    input  logic                 xfer_err,
    input  logic                 xfer_fatal
);
    seq_evt_t  evt;
    chan_sts_t sts;
    logic      susp_q, res_pend;
    ptr_t      cur;

    dcs_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (ctl_wr),
        .ctl_susp (ctl_susp),
        .ctl_res  (ctl_res),
        .sts_wr   (sts_wr),
        .sts_clr  (sts_clr),
        .busy     (busy),
        .evt      (evt),
        .susp_q   (susp_q),
        .res_pend (res_pend),
        .sts      (sts)
    );

    dcs_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_cmd  (ctl_wr && ctl_start),
        .start_addr (start_addr),
        .susp       (susp_q),
        .res_pend   (res_pend),
        .abort_q    (sts.abort),
        .eoc_q      (sts.eoc),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .xfer_done  (xfer_done),
        .xfer_err   (xfer_err),
        .xfer_fatal (xfer_fatal),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .xfer_req   (xfer_req),
        .cur        (cur),
        .busy       (busy),
        .parked     (parked),
        .evt        (evt)
    );

    assign sts_eoc   = sts.eoc;
    assign sts_abort = sts.abort;
    assign sts_err   = sts.err;
    assign cur_lo    = cur[WORD_W-1:0];
    assign cur_hi    = cur[PTR_W-1:WORD_W];
    assign xfer_desc = cur;

    assert_eoc_only_idle_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_eoc) |-> !busy);

    assert_abort_only_idle_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_abort) |-> !busy);

    assert_cur_matches_xfer_R11: assert property (@(posedge clk) disable iff (rst)
        xfer_req |-> ({cur_hi, cur_lo} == xfer_desc));
endmodule

// File: tb/desc_chain_seq_tb_top.sv
module desc_chain_seq_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic        ctl_wr = 0, ctl_start = 0, ctl_susp = 0, ctl_res = 0;
    logic [63:0] start_addr = '0;
    logic        sts_wr = 0;
    logic [2:0]  sts_clr = '0;
    logic        sts_eoc, sts_abort, sts_err, busy, parked;
    logic [31:0] cur_lo, cur_hi;
    logic        mem_req, mem_ack;
    logic [63:0] mem_addr;
    logic [31:0] mem_rdata;
    logic        xfer_req, xfer_done, xfer_err, xfer_fatal;
    logic [63:0] xfer_desc;

    desc_chain_seq dut_i (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_start(ctl_start), .ctl_susp(ctl_susp),
        .ctl_res(ctl_res), .start_addr(start_addr), .sts_wr(sts_wr), .sts_clr(sts_clr),
        .sts_eoc(sts_eoc), .sts_abort(sts_abort), .sts_err(sts_err), .busy(busy),
        .parked(parked), .cur_lo(cur_lo), .cur_hi(cur_hi), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .xfer_req(xfer_req),
        .xfer_desc(xfer_desc), .xfer_done(xfer_done), .xfer_err(xfer_err), .xfer_fatal(xfer_fatal)
    );

    logic [31:0] mem   [logic [63:0]];
    logic [1:0]  flags [logic [63:0]];   // bit0 non-fatal error, bit1 fatal
    logic [63:0] xlog  [$];
    int lat = 2;
    int cnt = 0;
    int total = 0, bad = 0;
    bit finished = 0;

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0; mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            xfer_done <= 0; xfer_err <= 0; xfer_fatal <= 0; cnt <= 0;
        end else if (xfer_done) begin
            xfer_done <= 0; xfer_err <= 0; xfer_fatal <= 0;
        end else if (xfer_req) begin
            if (cnt >= lat) begin
                cnt        <= 0;
                xfer_done  <= 1'b1;
                xfer_err   <= flags.exists(xfer_desc) ? flags[xfer_desc][0] : 1'b0;
                xfer_fatal <= flags.exists(xfer_desc) ? flags[xfer_desc][1] : 1'b0;
                xlog.push_back(xfer_desc);
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    function automatic void put_desc(logic [63:0] a, logic [63:0] n);
        mem[a]      = n[31:0];
        mem[a + 4]  = n[63:32];
    endfunction

    function automatic logic [63:0] rd_ptr(logic [63:0] a);
        logic [31:0] lo, hi;
        lo = mem.exists(a) ? mem[a] : 32'h0;
        hi = mem.exists(a + 4) ? mem[a + 4] : 32'h0;
        return {hi, lo};
    endfunction

    task automatic walk(input logic [63:0] head, output logic [63:0] q[$]);
        logic [63:0] p;
        q.delete();
        p = head;
        for (int i = 0; i < 64; i++) begin
            q.push_back(p);
            if (flags.exists(p) && flags[p][1]) break;
            p = rd_ptr(p);
            if (p == 64'h0) break;
        end
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_log(string req, logic [63:0] exp[$]);
        bit ok;
        ok = (xlog.size() == exp.size());
        for (int i = 0; ok && i < exp.size(); i++)
            if (xlog[i] !== exp[i]) ok = 0;
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%p expected=%p", req, xlog, exp);
        end
    endtask

    task automatic ctl(bit s, bit su, bit r, logic [63:0] a);
        @(negedge clk);
        ctl_wr = 1; ctl_start = s; ctl_susp = su; ctl_res = r; start_addr = a;
        @(negedge clk);
        ctl_wr = 0; ctl_start = 0; ctl_res = 0;
    endtask

    task automatic stclr(logic [2:0] m);
        @(negedge clk);
        sts_wr = 1; sts_clr = m;
        @(negedge clk);
        sts_wr = 0; sts_clr = '0;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] exp[$];
        logic [63:0] a [8];
        logic [31:0] hi;
        int len;
        bit any_err;
        void'($urandom(32'd4242));

        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // reset state
        chk("R1 reset busy", busy, 0);
        chk("R2 reset mem_req", mem_req, 0);
        chk("R3 reset eoc", sts_eoc, 0);
        chk("R5 reset abort", sts_abort, 0);
        chk("R4 reset err", sts_err, 0);
        chk("R11 reset cur", {cur_hi, cur_lo}, 64'h0);

        // random chains: R2 R3 R4 R11
        for (int t = 0; t < 6; t++) begin
            flags.delete();
            len = 1 + int'($urandom % 5);
            hi = (t % 2 == 1) ? ($urandom | 32'h1) : 32'h0;
            any_err = 0;
            for (int i = 0; i < len; i++) a[i] = {hi, 32'h0001_0000 * (t + 1) + 32'h40 * i};
            for (int i = 0; i < len; i++) begin
                put_desc(a[i], (i == len - 1) ? 64'h0 : a[i + 1]);
                if ($urandom % 4 == 0) begin flags[a[i]] = 2'b01; any_err = 1; end
            end
            lat = int'($urandom % 4);
            xlog.delete();
            ctl(1, 0, 0, a[0]);
            wait_idle();
            walk(a[0], exp);
            chk_log("R2 chain order", exp);
            chk("R3 eoc after null", sts_eoc, 1);
            chk("R4 nonfatal err flag", sts_err, any_err);
            chk("R11 cur is last", {cur_hi, cur_lo}, a[len - 1]);
            stclr(3'b111);
            chk("R10 w1c all", {sts_err, sts_abort, sts_eoc}, 3'b000);
        end

        // start while busy is ignored: R1
        flags.delete(); lat = 5;
        put_desc(64'h2_0000, 64'h2_0040);
        put_desc(64'h2_0040, 64'h2_0080);
        put_desc(64'h2_0080, 64'h0);
        put_desc(64'h3_0000, 64'h0);
        xlog.delete();
        ctl(1, 0, 0, 64'h2_0000);
        chk("R1 first read addr", mem_addr, 64'h2_0000);
        chk("R1 first read req", mem_req, 1);
        ctl(1, 0, 0, 64'h3_0000);
        wait_idle();
        walk(64'h2_0000, exp);
        chk_log("R1 start while busy ignored", exp);
        stclr(3'b111);

        // fatal error mid chain: R5 R6 R10
        put_desc(64'h4_0000, 64'h4_0040);
        put_desc(64'h4_0040, 64'h4_0080);
        put_desc(64'h4_0080, 64'h0);
        flags[64'h4_0040] = 2'b10;
        xlog.delete();
        ctl(1, 0, 0, 64'h4_0000);
        wait_idle();
        exp = '{64'h4_0000, 64'h4_0040};
        chk_log("R5 fatal stops chain", exp);
        chk("R5 abort set", sts_abort, 1);
        chk("R5 idle after abort", busy, 0);
        ctl(0, 0, 1, 64'h0);
        repeat (20) @(negedge clk);
        chk("R6 resume ignored busy", busy, 0);
        chk("R6 resume ignored xfers", xlog.size(), 2);
        stclr(3'b010);
        chk("R10 abort cleared", sts_abort, 0);
        flags.delete();

        // append after end of chain: R9
        put_desc(64'h5_0000, 64'h5_0040);
        put_desc(64'h5_0040, 64'h0);
        xlog.delete();
        ctl(1, 0, 0, 64'h5_0000);
        wait_idle();
        chk("R3 eoc before append", sts_eoc, 1);
        put_desc(64'h6_0000, {32'h0000_0002, 32'h0000_1000});
        put_desc({32'h0000_0002, 32'h0000_1000}, 64'h0);
        put_desc(64'h5_0040, 64'h6_0000);
        ctl(0, 0, 1, 64'h0);
        @(negedge clk);
        chk("R9 eoc cleared by resume", sts_eoc, 0);
        wait_idle();
        exp = '{64'h5_0000, 64'h5_0040, 64'h6_0000, {32'h0000_0002, 32'h0000_1000}};
        chk_log("R9 appended chain runs", exp);
        chk("R9 eoc at new end", sts_eoc, 1);
        stclr(3'b111);

        // suspend then splice: R7 R8 R11
        lat = 8;
        put_desc(64'h7_0000, 64'h7_0040);
        put_desc(64'h7_0040, 64'h7_0080);
        put_desc(64'h7_0080, 64'h0);
        xlog.delete();
        ctl(1, 0, 0, 64'h7_0000);
        ctl(0, 1, 0, 64'h0);
        for (int i = 0; i < 500 && !parked; i++) @(negedge clk);
        chk("R7 parked", parked, 1);
        chk("R11 cur at park", {cur_hi, cur_lo}, 64'h7_0000);
        repeat (10) @(negedge clk);
        chk("R7 no transfer while parked", xlog.size(), 1);
        chk("R7 no read while parked", mem_req, 0);
        put_desc(64'h8_0000, 64'h7_0040);
        put_desc(64'h7_0000, 64'h8_0000);
        ctl(0, 0, 1, 64'h0);
        wait_idle();
        exp = '{64'h7_0000, 64'h8_0000, 64'h7_0040, 64'h7_0080};
        chk_log("R8 splice after park", exp);
        stclr(3'b111);

        // append during last running transfer: R8 interlock
        put_desc(64'h9_0000, 64'h9_0040);
        put_desc(64'h9_0040, 64'h0);
        put_desc(64'hA_0000, 64'h0);
        xlog.delete();
        ctl(1, 0, 0, 64'h9_0000);
        for (int i = 0; i < 500 && !(xfer_req && xfer_desc == 64'h9_0040); i++) @(negedge clk);
        put_desc(64'h9_0040, 64'hA_0000);
        ctl(0, 0, 1, 64'h0);
        wait_idle();
        exp = '{64'h9_0000, 64'h9_0040, 64'hA_0000};
        chk_log("R8 resume during run rereads", exp);
        chk("R3 eoc after interlock", sts_eoc, 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule